// File: doc/BRIEF.md
# Multi-lane double-data-rate SPI read serializer

This block is the read side of a target SPI port on a data converter. A result word is first captured into a holding register by a load strobe. When the controller pulls chip select low, the block copies the held word and the current configuration into a working frame. It then shifts the word out, most significant bits first, over one, two or four SDO lanes. A new group of bits goes out on every SCLK transition, rising and falling alike.

Clock phase is fixed: a group is launched on an SCLK edge and the controller captures it on the following edge. The polarity setting decides whether the first launch is a rising or a falling edge. The block lives entirely in the system clock domain. SCLK and chip select are passed through synchronizer stages and edge-detected there, so the system clock must run several times faster than SCLK.

Each lane has an output enable that the pad ring uses to place an idle lane in high impedance. A lane is enabled only when three conditions hold together: chip select is low, the protocol field selects this mode, and the width setting includes that lane.

Top module: `ddr_sdo_serializer`

## Requirements
- R1: While the synchronized chip select is high, and after reset, every `sdo_oe` bit is 0 and every `sdo` bit is 0.
- R2: The frame is served only when `proto_sel` equals 3'b001 at the chip-select falling edge. With any other value, `sdo_oe` and `sdo` stay 0 for the whole frame, whatever SCLK does.
- R3: `width_sel` selects the enabled lanes. 2'b00 enables lane 0, 2'b01 enables lanes 1:0, and 2'b10 or 2'b11 enable lanes 3:0. A lane that is not enabled has its `sdo_oe` bit at 0 and drives `sdo` 0.
- R4: Bits leave most significant first. For an n-lane width, each launch places the next n bits on lanes n-1..0, and the higher-order bit of the group goes on the higher-numbered lane.
- R5: With `cpol`=0 the first launch happens on the first SCLK rising edge. With `cpol`=1 it happens on the first falling edge. An edge of the opposite direction that comes before the first launch is ignored, and the outputs stay 0.
- R6: After the first launch, every SCLK edge of either direction launches the next group. Between edges, `sdo` holds its value.
- R7: When `len_short`=1, only `word[13:0]` is sent, as 14 bits. In four-lane width the fourth group carries `word[1:0]` on lanes 3 and 2, and lanes 1 and 0 carry 0.
- R8: Once every bit of the word has been launched, further SCLK edges drive 0 on the enabled lanes until chip select rises.
- R9: `proto_sel`, `cpol`, `width_sel` and `len_short` are sampled only at the chip-select falling edge. Changing them in the middle of a frame does not affect that frame.
- R10: A `word_load` pulse captures `word_in`. A frame sends the word captured by the last pulse before chip select fell, and a pulse during a frame does not change that frame's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low, asynchronous |
| sclk | input | 1 | SPI serial clock, asynchronous |
| word_in | input | 16 | Result word to capture |
| word_load | input | 1 | Capture strobe for `word_in` |
| proto_sel | input | 3 | Read protocol select; 3'b001 selects this mode |
| cpol | input | 1 | SCLK idle level and direction of the first launch edge |
| width_sel | input | 2 | Lane count: 00 one, 01 two, 10/11 four |
| len_short | input | 1 | 1 sends a 14-bit word |
| sdo | output | 4 | Lane data, 0 where not enabled |
| sdo_oe | output | 4 | Per-lane drive enable; 0 means high impedance |

## Verification
The assertions assume two things about SCLK and chip select. First, each level lasts longer than the synchronizer depth plus one system cycle, so no edge is lost or merged. Second, SCLK rests at its `cpol` level whenever chip select falls. The stimulus holds every SCLK and chip-select level for eight system cycles and always parks SCLK at its idle level before a frame. The one exception is a deliberate case in which SCLK starts at the wrong level, used to show that the opposite-direction edge is ignored. Configuration and load changes are applied only between system clock edges, and the frame outcome is judged only from the lanes sampled six cycles after each SCLK transition.

// File: rtl/ddrs_pkg.sv
package ddrs_pkg;

    localparam logic [2:0] PROTO_DDR = 3'b001;

    // log2 of the lane count selected by the width field
    function automatic logic [1:0] width_log(input logic [1:0] code);
        logic [1:0] r;
        case (code)
            2'b00:   r = 2'd0;
            2'b01:   r = 2'd1;
            default: r = 2'd2;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ddrs_edge_sync.sv
module ddrs_edge_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    localparam int PIPE_W = STAGES + 1;

    logic [PIPE_W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[PIPE_W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {PIPE_W{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign lvl  = pipe_q[STAGES-1];
    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall = ~pipe_q[STAGES-1] & pipe_q[STAGES];

endmodule

// File: rtl/ddrs_shifter.sv
module ddrs_shifter
    import ddrs_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int SHORT_W = 14,
    parameter int LANES   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              cs_rise,
    input  logic              cs_fall,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_load,
    input  logic [2:0]        proto_sel,
    input  logic              cpol,
    input  logic [1:0]        width_sel,
    input  logic              len_short,
    output logic [LANES-1:0]  sdo,
    output logic [LANES-1:0]  sdo_oe
);
    localparam int PAD_W = WORD_W - SHORT_W;

    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic [WORD_W-1:0] shreg;
        logic [1:0]        wlog;
        logic              pol;
        logic              active;
        logic              started;
        logic [LANES-1:0]  out;
        logic [LANES-1:0]  oe;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [LANES-1:0] lane_mask(input logic [1:0] wl);
        int n;
        n = 1 << wl;
        return LANES'((1 << n) - 1);
    endfunction

    int                n_lanes;
    logic [WORD_W-1:0] shifted;
    logic [LANES-1:0]  grp;
    logic              sck_edge;
    logic              launch_ok;

    always_comb begin
        st_d      = st_q;
        n_lanes   = 1 << st_q.wlog;
        shifted   = st_q.shreg >> (WORD_W - n_lanes);
        grp       = shifted[LANES-1:0] & lane_mask(st_q.wlog);
        sck_edge  = sck_rise | sck_fall;
        launch_ok = st_q.started | (st_q.pol ? sck_fall : sck_rise);

        if (word_load) st_d.hold = word_in;

        if (cs_lvl || cs_rise) begin
            st_d.active  = 1'b0;
            st_d.started = 1'b0;
            st_d.out     = '0;
            st_d.oe      = '0;
        end else if (cs_fall) begin
            st_d.shreg   = len_short ? {st_q.hold[SHORT_W-1:0], {PAD_W{1'b0}}}
                                     : st_q.hold;
            st_d.wlog    = width_log(width_sel);
            st_d.pol     = cpol;
            st_d.active  = (proto_sel == PROTO_DDR);
            st_d.started = 1'b0;
            st_d.out     = '0;
            st_d.oe      = (proto_sel == PROTO_DDR) ? lane_mask(width_log(width_sel)) : '0;
        end else if (st_q.active && sck_edge && launch_ok) begin
            st_d.started = 1'b1;
            st_d.out     = grp;
            st_d.shreg   = st_q.shreg << n_lanes;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo    = st_q.out;
    assign sdo_oe = st_q.oe;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> (sdo_oe == '0 && sdo == '0));

    p_proto_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && proto_sel != PROTO_DDR) |=> (sdo_oe == '0));

    p_lane_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((sdo_oe & (sdo_oe + 1'b1)) == '0) && ((sdo & ~sdo_oe) == '0));

    p_hold_between_edges_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_lvl && !cs_fall && !sck_rise && !sck_fall) |=> $stable(sdo));

endmodule

// File: rtl/ddr_sdo_serializer.sv
module ddr_sdo_serializer #(
    parameter int WORD_W      = 16,
    parameter int SHORT_W     = 14,
    parameter int LANES       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_load,
    input  logic [2:0]        proto_sel,
    input  logic              cpol,
    input  logic [1:0]        width_sel,
    input  logic              len_short,
    output logic [LANES-1:0]  sdo,
    output logic [LANES-1:0]  sdo_oe
);
    logic cs_lvl, cs_rise, cs_fall;
    logic sck_lvl, sck_rise, sck_fall;

    ddrs_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .din(cs_n),
        .lvl(cs_lvl), .rise(cs_rise), .fall(cs_fall)
    );

    ddrs_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .din(sclk),
        .lvl(sck_lvl), .rise(sck_rise), .fall(sck_fall)
    );

    ddrs_shifter #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .LANES(LANES)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .cs_lvl(cs_lvl), .cs_rise(cs_rise), .cs_fall(cs_fall),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .word_in(word_in), .word_load(word_load),
        .proto_sel(proto_sel), .cpol(cpol), .width_sel(width_sel),
        .len_short(len_short),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    // a synchronized SCLK edge always agrees with the synchronized level
    p_sck_edge_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_rise |-> sck_lvl) and (sck_fall |-> !sck_lvl));

endmodule

// File: tb/tb_ddr_sdo_serializer.sv
module tb_ddr_sdo_serializer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic [15:0] word_in = '0;
    logic        word_load = 1'b0;
    logic [2:0]  proto_sel = 3'b001;
    logic        cpol = 1'b0;
    logic [1:0]  width_sel = 2'b00;
    logic        len_short = 1'b0;
    logic [3:0]  sdo;
    logic [3:0]  sdo_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    ddr_sdo_serializer dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .word_in(word_in), .word_load(word_load), .proto_sel(proto_sel),
        .cpol(cpol), .width_sel(width_sel), .len_short(len_short),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    // {word[15:0], width[1:0], cpol, short}
    localparam logic [19:0] VEC [10] = '{
        20'hA5C3_0, 20'h3C96_2, 20'hF00F_4, 20'h1234_6, 20'h8001_8,
        20'h7E5A_A, 20'hEABC_1, 20'h3FFF_7, 20'hDE35_9, 20'h9BDF_E
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int lanes_of(input logic [1:0] wd);
        return (wd == 2'b00) ? 1 : (wd == 2'b01) ? 2 : 4;
    endfunction

    task automatic run_frame(input logic [15:0] w, input logic [1:0] wd, input logic c,
                             input logic s, input logic [2:0] pr, input bit mid,
                             output logic [15:0] got, output bit oe_ok, output bit tail_ok);
        int n, len, grps;
        logic [31:0] acc;
        logic [3:0] lowm, expm;
        logic lvl;
        word_in = w; word_load = 1'b1;
        wait_n(1);
        word_load = 1'b0; word_in = 16'h0BAD;
        proto_sel = pr; cpol = c; width_sel = wd; len_short = s; sclk = c;
        wait_n(8);
        cs_n = 1'b0;
        wait_n(8);
        n    = lanes_of(wd);
        len  = s ? 14 : 16;
        grps = (len + n - 1) / n;
        lowm = 4'((1 << n) - 1);
        expm = (pr == 3'b001) ? lowm : 4'h0;
        acc  = '0;
        oe_ok   = (sdo_oe == expm) && (sdo == 4'h0);
        tail_ok = 1'b1;
        lvl = c;
        for (int e = 0; e < 18; e++) begin
            lvl = ~lvl; sclk = lvl;
            wait_n(6);
            if (sdo_oe != expm) oe_ok = 1'b0;
            if ((sdo & ~sdo_oe) != 4'h0) oe_ok = 1'b0;
            if (e < grps) acc = (acc << n) | 32'(sdo & lowm);
            else if (sdo != 4'h0) tail_ok = 1'b0;
            if (mid && e == 1) begin
                width_sel = ~wd; cpol = ~c; proto_sel = 3'b011; len_short = ~s;
                word_in = 16'h5555; word_load = 1'b1;
                wait_n(1);
                word_load = 1'b0;
                wait_n(1);
            end else begin
                wait_n(2);
            end
        end
        got = 16'(acc >> (grps * n - len));
        cs_n = 1'b1;
        wait_n(8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] got;
        bit oe_ok, tail_ok;

        wait_n(4);
        check("R1 reset oe", 32'(sdo_oe), 32'h0);
        check("R1 reset sdo", 32'(sdo), 32'h0);
        rst_n = 1'b1;
        wait_n(6);
        check("R1 idle oe after reset", 32'(sdo_oe), 32'h0);

        for (int i = 0; i < 10; i++) begin
            logic [15:0] w;
            logic [1:0]  wd;
            logic        c, s;
            w  = VEC[i][19:4];
            wd = VEC[i][3:2];
            c  = VEC[i][1];
            s  = VEC[i][0];
            run_frame(w, wd, c, s, 3'b001, 1'b0, got, oe_ok, tail_ok);
            check(s ? "R7 short word data" : "R4 R5 R6 R10 word data",
                  32'(got), s ? 32'(w & 16'h3FFF) : 32'(w));
            check("R3 lane enables", 32'(oe_ok), 32'h1);
            check("R8 zero tail", 32'(tail_ok), 32'h1);
            check("R1 idle after frame", 32'({sdo_oe, sdo}), 32'h0);
        end

        // R2: protocol field other than 001 keeps lanes off
        run_frame(16'hFFFF, 2'b10, 1'b0, 1'b0, 3'b010, 1'b0, got, oe_ok, tail_ok);
        check("R2 disabled data", 32'(got), 32'h0);
        check("R2 disabled oe", 32'(oe_ok), 32'h1);

        // R9 and R10: mid-frame config change and word load have no effect
        run_frame(16'hB2D4, 2'b01, 1'b0, 1'b0, 3'b001, 1'b1, got, oe_ok, tail_ok);
        check("R9 R10 mid-frame change data", 32'(got), 32'hB2D4);
        check("R9 mid-frame change oe", 32'(oe_ok), 32'h1);

        // R5: cpol=1 with SCLK resting low; the first rising edge is ignored
        word_in = 16'hC35A; word_load = 1'b1;
        wait_n(1);
        word_load = 1'b0;
        proto_sel = 3'b001; cpol = 1'b1; width_sel = 2'b10; len_short = 1'b0; sclk = 1'b0;
        wait_n(8);
        cs_n = 1'b0;
        wait_n(8);
        sclk = 1'b1; wait_n(6);
        check("R5 opposite edge ignored", 32'(sdo), 32'h0);
        wait_n(2);
        sclk = 1'b0; wait_n(6);
        check("R5 first falling launch", 32'(sdo), 32'hC);
        wait_n(2);
        sclk = 1'b1; wait_n(6);
        check("R6 next edge launch", 32'(sdo), 32'h3);
        wait_n(2);
        cs_n = 1'b1;
        wait_n(8);
        check("R1 idle after cs rise", 32'({sdo_oe, sdo}), 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule